// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM command bus. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins. It also checks whether the clock-enable pin was high in the cycle before. From this it works out which command arrived. It keeps an open-or-closed state and a latched row address for each of four banks, and it holds the programmed burst length, burst ordering and CAS latency.

Every accepted edge produces a registered command code and a one-cycle error flag. An illegal command raises the flag and is dropped without touching any state. Illegal commands are: a column access to a closed bank, opening a bank that is already open, and a mode load or refresh while any bank is open. Precharge closes one bank or every bank. A column access with the auto-close address bit set closes its bank on its own once the programmed burst has run out. A storage-array model can use the bank state and row outputs directly, and so can a protocol monitor.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is held low, and until the first edge after it, `cmd_code` is 1, `err` is 0, `bank_open` is 0, `burst_code` is 0, `interleave` is 0 and `cas_lat` is 3.
- R2: If `cke` was low at the previous rising edge, the current edge is ignored. `cmd_code` becomes 0, no bank or mode state changes, and auto-close countdowns do not advance.
- R3: An edge with `cs_n` high gives `cmd_code` 1 and no error. Bank state is unchanged, except that auto-close countdowns already running keep advancing.
- R4: With `cs_n` low, the pins {ras_n,cas_n,we_n} decode as follows, with the code appearing on `cmd_code` one cycle after the edge: 111 idle (2); 110 burst stop (3); 101 read (4, or 5 when addr[10] is high); 100 write (6, or 7 when addr[10] is high); 011 activate (8); 010 precharge (9 for one bank, 10 when addr[10] is high); 001 refresh (11); 000 mode load (12).
- R5: Activate opens bank `ba` and latches `addr` as its row on `open_row[12*ba +: 12]`. An activate to an open bank raises `err` and leaves the stored row unchanged.
- R6: A read or write raises `err` if bank `ba` is closed or is counting down an auto-close. Column commands to open banks may follow each other on consecutive edges with no error.
- R7: Precharge with addr[10] low closes only bank `ba`. With addr[10] high it closes every bank, whatever `ba` holds.
- R8: A read or write with addr[10] high closes its bank after the valid edge that comes a burst length of valid edges later. A precharge of that bank ends the countdown.
- R9: Mode load takes the burst code from addr[2:0], where 0, 1, 2, 3 and 7 give 1, 2, 4, 8 and 512 beats and any other code gives 1 beat. It takes interleaved ordering from addr[3] and CAS latency from addr[6:4]. A latency other than 2 or 3 raises `err` and keeps the old mode.
- R10: Mode load or refresh while any bank is open raises `err` and has no effect.
- R11: A command that raises `err` changes no bank state and no mode state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; when low, the next edge is ignored |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column or mode value; bit 10 selects auto-close or all-bank |
| cmd_code | output | 4 | Code of the command decoded at the last edge |
| err | output | 1 | The last edge carried an illegal command |
| bank_open | output | 4 | One bit per bank, high while open |
| open_row | output | 48 | Latched row per bank, bank b at bits 12*b+11 down to 12*b |
| burst_code | output | 3 | Programmed burst length code |
| interleave | output | 1 | Programmed burst ordering, 1 for interleaved |
| cas_lat | output | 2 | Programmed CAS latency, 2 or 3 |

## Verification
The assertions take for granted that `ba` and `addr` hold a settled value at each edge. They also assume `rst_n` is held across at least one edge before any command is sent. They do not rely on the command stream being legal: illegal orders are covered as well, and must leave the mode register and the bank state intact. The stimulus changes inputs only on the falling edge and returns the pins to idle with `cke` high after each command, so any suspended edge is one the test chose. It opens and closes banks only in orders whose outcome is fixed by the requirements.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int BANKS     = 4,
  parameter int ROW_W     = 12,
  parameter int FULL_PAGE = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [$clog2(BANKS)-1:0] ba,
  input  logic [ROW_W-1:0]         addr,
  output logic [3:0]               cmd_code,
  output logic                     err,
  output logic [BANKS-1:0]         bank_open,
  output logic [BANKS*ROW_W-1:0]   open_row,
  output logic [2:0]               burst_code,
  output logic                     interleave,
  output logic [1:0]               cas_lat
);
  localparam int BA_W  = $clog2(BANKS);
  localparam int CNT_W = $clog2(FULL_PAGE + 1);
  localparam int AP    = 10;

  localparam logic [3:0] C_IGN = 4'd0, C_DES = 4'd1, C_NOP = 4'd2, C_BST = 4'd3,
                         C_RD  = 4'd4, C_RDA = 4'd5, C_WR  = 4'd6, C_WRA = 4'd7,
                         C_ACT = 4'd8, C_PRE = 4'd9, C_PAL = 4'd10, C_REF = 4'd11,
                         C_MRS = 4'd12;

  logic             cke_q;
  logic [3:0]       dec;
  logic             bad;
  logic [ROW_W-1:0] row_q [BANKS];
  logic [CNT_W-1:0] cnt_q [BANKS];

  function automatic logic [CNT_W-1:0] beats(input logic [2:0] c);
    case (c)
      3'd1:    beats = CNT_W'(2);
      3'd2:    beats = CNT_W'(4);
      3'd3:    beats = CNT_W'(8);
      3'd7:    beats = CNT_W'(FULL_PAGE);
      default: beats = CNT_W'(1);
    endcase
  endfunction

  always_comb begin
    if (!cke_q)    dec = C_IGN;
    else if (cs_n) dec = C_DES;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  dec = C_NOP;
        3'b110:  dec = C_BST;
        3'b101:  dec = addr[AP] ? C_RDA : C_RD;
        3'b100:  dec = addr[AP] ? C_WRA : C_WR;
        3'b011:  dec = C_ACT;
        3'b010:  dec = addr[AP] ? C_PAL : C_PRE;
        3'b001:  dec = C_REF;
        default: dec = C_MRS;
      endcase
    end
  end

  wire sel_open = bank_open[ba];
  wire sel_busy = cnt_q[ba] != '0;
  wire any_open = |bank_open;
  wire cl_ok    = addr[6:4] == 3'd2 || addr[6:4] == 3'd3;

  always_comb begin
    case (dec)
      C_RD, C_RDA, C_WR, C_WRA: bad = !sel_open || sel_busy;
      C_ACT:                    bad = sel_open;
      C_REF:                    bad = any_open;
      C_MRS:                    bad = any_open || !cl_ok;
      default:                  bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q      <= 1'b1;
      cmd_code   <= C_DES;
      err        <= 1'b0;
      burst_code <= 3'd0;
      interleave <= 1'b0;
      cas_lat    <= 2'd3;
    end else begin
      cke_q    <= cke;
      cmd_code <= dec;
      err      <= bad;
      if (dec == C_MRS && !bad) begin
        burst_code <= addr[2:0];
        interleave <= addr[3];
        cas_lat    <= addr[5:4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open <= '0;
      for (int b = 0; b < BANKS; b++) begin
        row_q[b] <= '0;
        cnt_q[b] <= '0;
      end
    end else if (cke_q) begin
      for (int b = 0; b < BANKS; b++) begin
        if (cnt_q[b] != '0) begin
          cnt_q[b] <= cnt_q[b] - 1'b1;
          if (cnt_q[b] == CNT_W'(1)) bank_open[b] <= 1'b0;
        end
        if (!bad) begin
          if (dec == C_ACT && ba == BA_W'(b)) begin
            bank_open[b] <= 1'b1;
            row_q[b]     <= addr;
          end
          if ((dec == C_RDA || dec == C_WRA) && ba == BA_W'(b))
            cnt_q[b] <= beats(burst_code);
          if ((dec == C_PRE && ba == BA_W'(b)) || dec == C_PAL) begin
            bank_open[b] <= 1'b0;
            cnt_q[b]     <= '0;
          end
        end
      end
    end
  end

  always_comb
    for (int b = 0; b < BANKS; b++) open_row[b*ROW_W +: ROW_W] = row_q[b];

  a_r2_stalled_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> (cmd_code == C_IGN && $stable(bank_open)));

  a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_ACT && !err) |-> bank_open[$past(ba)]);

  a_r7_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == C_PAL |-> bank_open == '0);

  a_r9_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cas_lat == 2'd2 || cas_lat == 2'd3);

  a_r10_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == C_REF || cmd_code == C_MRS) && !err) |-> $past(bank_open) == '0);

  a_r11_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable({burst_code, interleave, cas_lat}));
endmodule

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;
  logic clk = 0, rst_n = 0, cke = 1, cs_n = 0, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [11:0] addr = 0;
  logic [3:0] cmd_code, bank_open;
  logic err, interleave;
  logic [47:0] open_row;
  logic [2:0] burst_code;
  logic [1:0] cas_lat;
  int checks = 0, fails = 0;

  localparam logic [3:0] P_NOP = 4'b0111, P_BST = 4'b0110, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_ACT = 4'b0011, P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000,
                         P_DES = 4'b1111;
  localparam logic [11:0] APB = 12'h400;

  typedef struct packed { logic [3:0] cmd; logic err; logic [3:0] open; } exp_t;
  exp_t eq[$];
  string tq[$];

  always #2 clk = ~clk;

  sdram_cmd_tracker u_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code), .err(err),
    .bank_open(bank_open), .open_row(open_row), .burst_code(burst_code),
    .interleave(interleave), .cas_lat(cas_lat));

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic k, input logic [3:0] pins, input logic [1:0] b,
                       input logic [11:0] a, input logic [3:0] ecmd, input logic eerr,
                       input logic [3:0] eopen, input string tag);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = pins; ba = b; addr = a;
    eq.push_back('{ecmd, eerr, eopen});
    tq.push_back(tag);
    @(posedge clk); #1;
    cke = 1; {cs_n, ras_n, cas_n, we_n} = P_NOP;
  endtask

  initial forever begin
    @(posedge clk); #1;
    if (eq.size() > 0) begin
      exp_t e;
      string t;
      e = eq.pop_front();
      t = tq.pop_front();
      chk(t, {39'd0, cmd_code, err, bank_open}, {39'd0, e.cmd, e.err, e.open});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", {cmd_code, err, bank_open, burst_code, interleave, cas_lat},
        {4'd1, 1'b0, 4'd0, 3'd0, 1'b0, 2'd3});
    rst_n = 1;
    issue(1, P_MRS, 0, 12'h02A, 4'd12, 0, 4'b0000, "R9 mode load");
    chk("R9 mode fields", {burst_code, interleave, cas_lat}, {3'd2, 1'b1, 2'd2});
    issue(1, P_MRS, 0, 12'h050, 4'd12, 1, 4'b0000, "R9 bad latency");
    chk("R11 mode kept", {burst_code, interleave, cas_lat}, {3'd2, 1'b1, 2'd2});
    issue(1, P_ACT, 0, 12'hABC, 4'd8, 0, 4'b0001, "R5 activate");
    chk("R5 row bank0", open_row[11:0], 12'hABC);
    issue(1, P_ACT, 2, 12'h123, 4'd8, 0, 4'b0101, "R5 activate bank2");
    issue(1, P_ACT, 0, 12'h3C3, 4'd8, 1, 4'b0101, "R5 activate open bank");
    chk("R11 row kept", open_row[11:0], 12'hABC);
    chk("R5 row bank2", open_row[35:24], 12'h123);
    issue(1, P_RD, 1, 12'h000, 4'd4, 1, 4'b0101, "R6 read closed bank");
    issue(1, P_RD, 0, 12'h000, 4'd4, 0, 4'b0101, "R6 read");
    issue(1, P_WR, 2, 12'h004, 4'd6, 0, 4'b0101, "R6 write next cycle");
    issue(1, P_REF, 0, 12'h000, 4'd11, 1, 4'b0101, "R10 refresh while open");
    issue(1, P_PRE, 0, 12'h000, 4'd9, 0, 4'b0100, "R7 single precharge");
    issue(1, P_PRE, 1, APB, 4'd10, 0, 4'b0000, "R7 all precharge");
    issue(1, P_REF, 0, 12'h000, 4'd11, 0, 4'b0000, "R4 refresh idle");
    issue(1, P_DES, 0, 12'h000, 4'd1, 0, 4'b0000, "R3 deselect");
    issue(1, P_ACT, 3, 12'hFFF, 4'd8, 0, 4'b1000, "R5 activate bank3");
    issue(1, P_RD, 3, APB, 4'd5, 0, 4'b1000, "R8 read auto close");
    issue(1, P_RD, 3, 12'h000, 4'd4, 1, 4'b1000, "R6 read while closing");
    issue(1, P_DES, 0, 12'h000, 4'd1, 0, 4'b1000, "R3 countdown under deselect");
    issue(1, P_NOP, 0, 12'h000, 4'd2, 0, 4'b1000, "R8 last beat");
    issue(1, P_NOP, 0, 12'h000, 4'd2, 0, 4'b0000, "R8 closed after burst");
    issue(1, P_ACT, 1, 12'h055, 4'd8, 0, 4'b0010, "R5 activate bank1");
    chk("R5 row bank1", open_row[23:12], 12'h055);
    issue(1, P_WR, 1, APB, 4'd7, 0, 4'b0010, "R8 write auto close");
    issue(0, P_NOP, 0, 12'h000, 4'd2, 0, 4'b0010, "R2 cke low");
    issue(1, P_NOP, 0, 12'h000, 4'd0, 0, 4'b0010, "R2 ignored edge");
    issue(1, P_NOP, 0, 12'h000, 4'd2, 0, 4'b0010, "R2 frozen countdown");
    issue(1, P_NOP, 0, 12'h000, 4'd2, 0, 4'b0010, "R8 beat");
    issue(1, P_NOP, 0, 12'h000, 4'd2, 0, 4'b0000, "R8 closed after stall");
    issue(0, P_NOP, 0, 12'h000, 4'd2, 0, 4'b0000, "R2 cke low again");
    issue(1, P_ACT, 0, 12'h010, 4'd0, 0, 4'b0000, "R2 activate ignored");
    issue(1, P_ACT, 0, 12'h010, 4'd8, 0, 4'b0001, "R5 activate after stall");
    issue(1, P_MRS, 0, 12'h031, 4'd12, 1, 4'b0001, "R10 mode load while open");
    chk("R10 mode kept", {burst_code, interleave, cas_lat}, {3'd2, 1'b1, 2'd2});
    issue(1, P_PRE, 2, APB, 4'd10, 0, 4'b0000, "R7 all precharge any ba");
    issue(1, P_MRS, 0, 12'h031, 4'd12, 0, 4'b0000, "R9 burst of two");
    chk("R9 mode fields 2", {burst_code, interleave, cas_lat}, {3'd1, 1'b0, 2'd3});
    issue(1, P_ACT, 2, 12'h777, 4'd8, 0, 4'b0100, "R5 activate bank2 again");
    issue(1, P_WR, 2, APB, 4'd7, 0, 4'b0100, "R8 write two beats");
    issue(1, P_NOP, 0, 12'h000, 4'd2, 0, 4'b0100, "R8 second beat");
    issue(1, P_NOP, 0, 12'h000, 4'd2, 0, 4'b0000, "R8 closed two beats");
    issue(1, P_ACT, 0, 12'h001, 4'd8, 0, 4'b0001, "R5 activate bank0");
    issue(1, P_RD, 0, APB, 4'd5, 0, 4'b0001, "R8 read auto close bank0");
    issue(1, P_PRE, 0, 12'h000, 4'd9, 0, 4'b0000, "R8 precharge during countdown");
    issue(1, P_ACT, 0, 12'h0F0, 4'd8, 0, 4'b0001, "R5 reopen bank0");
    issue(1, P_BST, 0, 12'h000, 4'd3, 0, 4'b0001, "R4 burst stop");
    issue(1, P_RD, 0, 12'h008, 4'd4, 0, 4'b0001, "R6 read");
    issue(1, P_WR, 0, 12'h010, 4'd6, 0, 4'b0001, "R6 write right after read");
    chk("R5 row reopened", open_row[11:0], 12'h0F0);
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule